// File: doc/BRIEF.md
# Four-Bank DRAM Strobe Controller with Column Extension and Hidden Refresh

This block drives the row strobes of a four-bank dynamic memory array and a shared column strobe. A two-bit bank code is captured whenever the address-strobe input is high. When a row request arrives while the chip select is active, only the row strobe of the captured bank goes low. The column strobe then follows a fixed number of clocks later. The access lasts until the row request is withdrawn.

A separate fast access mode serves quick memory cycles. In this mode the row strobe can end early while the column strobe stays low under control of a column-hold input, so read data stays valid for longer. When the chip select is inactive, a row request in normal mode is taken as a hidden refresh and drives all four row strobes low. Only one hidden refresh is granted per refresh-clock period. The block also raises a refresh request on each refresh-clock period in normal mode. Fast access mode has no refresh request, ignores the refresh clock and grants no hidden refresh.

All behaviour is synchronous to one system clock. Every strobe is active low.

Top module: `dram_strobe_ctrl`

## Requirements
- R1: After reset, all four row strobes and the column strobe are high and refresh_req is 0.
- R2: On each clock where addr_strobe is 1, bank_code is captured. When row_req_n is sampled low after being high, sel_n is low and no access is in progress, the row strobe for the captured code goes low on the next clock and the others stay high. Code 0 selects row_strobe_n[0], code 1 selects [1], code 2 selects [2] and code 3 selects [3]. A bank_code change without addr_strobe has no effect on which strobe is driven.
- R3: During an access, col_strobe_n goes low exactly CAS_DELAY clocks after the selected row strobe falls, in both modes.
- R4: When row_req_n is sampled high during an access, the row strobe returns high on the next clock. In normal mode the column strobe returns high on the same clock.
- R5: In fast mode (fast_mode = 1), suppose col_hold_n is low and the column strobe is already low when the access ends. Then col_strobe_n stays low after the row strobe rises. It returns high on the clock after col_hold_n is sampled high.
- R6: If col_hold_n is high when an access ends, or if the block is in normal mode, the column strobe is not extended.
- R7: In normal mode, a high-to-low transition of row_req_n that is sampled while sel_n is high and hidden refresh is still allowed drives all four row strobes low on the next clock. They stay low until row_req_n is sampled high. The column strobe stays high throughout.
- R8: After one hidden refresh, further such requests in the same refresh-clock period drive no row strobe.
- R9: A rising edge of refresh_clk, taken as the first clock where refresh_clk is sampled 1 after being sampled 0, starts a new period and allows a new hidden refresh.
- R10: In normal mode, a rising edge of refresh_clk sets refresh_req on the next clock. The start of a hidden refresh clears it.
- R11: In fast mode, refresh_req stays 0, refresh_clk edges are ignored, and a row request without chip select drives no row strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fast_mode | input | 1 | 1 selects fast access mode |
| addr_strobe | input | 1 | Captures bank_code while high |
| bank_code | input | 2 | Bank select code |
| sel_n | input | 1 | Chip select, active low |
| row_req_n | input | 1 | Row strobe request, active low |
| col_hold_n | input | 1 | Column-strobe hold in fast mode, active low |
| refresh_clk | input | 1 | Refresh period clock, sampled |
| row_strobe_n | output | 4 | Row strobes, active low, one per bank |
| col_strobe_n | output | 1 | Column strobe, active low |
| refresh_req | output | 1 | Refresh request, active high |

## Verification
The assertions check several properties on every cycle. At most one row strobe is low unless all four are. A hidden-refresh start is followed by all four strobes low. A hidden refresh is never granted twice in one period, and never in fast mode. The end of an access releases the row strobes, and in steady normal mode the column strobe is never low without a row strobe. Bank capture is also checked against the code presented one clock earlier. Only the bench scenarios can show the timing of the column strobe after the row falls, how long the fast-mode extension lasts, the bank-to-strobe mapping, and the way refresh-clock edges reopen hidden refresh and set the request. These are compared on every clock against a behavioural model.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

    localparam int BANK_W    = 2;
    localparam int NUM_BANKS = 1 << BANK_W;

    typedef enum logic [1:0] {
        SEQ_IDLE    = 2'd0,
        SEQ_ACCESS  = 2'd1,
        SEQ_REFRESH = 2'd2
    } seq_state_e;

    // request inputs normalised to active high
    typedef struct packed {
        logic row_req;
        logic sel;
        logic col_hold;
    } strobe_in_t;

    function automatic logic [NUM_BANKS-1:0] bank_enable(input logic [BANK_W-1:0] code);
        logic [NUM_BANKS-1:0] en;
        for (int i = 0; i < NUM_BANKS; i++) begin
            en[i] = (code == BANK_W'(i));
        end
        return en;
    endfunction

endpackage

// File: rtl/dsc_bank_latch.sv
module dsc_bank_latch #(
    parameter int W = dsc_pkg::BANK_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         capture,
    input  logic [W-1:0] code_i,
    output logic [W-1:0] code_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            code_o <= '0;
        end else if (capture) begin
            code_o <= code_i;
        end
    end

    assert_bank_capture_R2: assert property (@(posedge clk) disable iff (rst)
        capture |=> (code_o == $past(code_i)));

endmodule

// File: rtl/dsc_refresh_tracker.sv
module dsc_refresh_tracker (
    input  logic clk,
    input  logic rst,
    input  logic fast_mode,
    input  logic refresh_clk,
    input  logic start_hidden_i,
    output logic hidden_ok_o,
    output logic refresh_req_o
);

    logic rf_q;
    logic done_q;
    logic req_q;
    logic period_rise;

    // edges of the refresh clock only count outside fast mode
    assign period_rise = !fast_mode && refresh_clk && !rf_q;
    assign hidden_ok_o = !fast_mode && (!done_q || period_rise);
    assign refresh_req_o = req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rf_q   <= 1'b0;
            done_q <= 1'b0;
            req_q  <= 1'b0;
        end else begin
            rf_q <= refresh_clk;
            if (start_hidden_i) begin
                done_q <= 1'b1;
            end else if (period_rise) begin
                done_q <= 1'b0;
            end
            if (fast_mode || start_hidden_i) begin
                req_q <= 1'b0;
            end else if (period_rise) begin
                req_q <= 1'b1;
            end
        end
    end

    assert_one_per_period_R8: assert property (@(posedge clk) disable iff (rst)
        (done_q && !period_rise) |-> !start_hidden_i);

    assert_no_hidden_fast_R11: assert property (@(posedge clk) disable iff (rst)
        fast_mode |-> !start_hidden_i);

endmodule

// File: rtl/dsc_strobe_seq.sv
module dsc_strobe_seq
    import dsc_pkg::*;
#(
    parameter int unsigned CAS_DELAY = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 fast_mode,
    input  strobe_in_t           req_i,
    input  logic [BANK_W-1:0]    bank_i,
    input  logic                 hidden_ok_i,
    output logic [NUM_BANKS-1:0] row_n_o,
    output logic                 col_n_o,
    output logic                 start_hidden_o
);

    localparam int CNT_W = $clog2(CAS_DELAY + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CAS_DELAY);

    seq_state_e        state_q, state_d;
    logic [BANK_W-1:0] act_bank_q, act_bank_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic              ext_q, ext_d;
    logic              req_prev_q;
    logic              req_fall;
    logic              col_on;
    logic              ext_set;
    logic              start_access;

    assign req_fall     = req_i.row_req && !req_prev_q;
    assign col_on       = (state_q == SEQ_ACCESS) && (cnt_q == CNT_LAST);
    assign start_access = (state_q == SEQ_IDLE) && req_fall && req_i.sel;
    assign start_hidden_o = (state_q == SEQ_IDLE) && req_fall && !req_i.sel && hidden_ok_i;
    assign ext_set = (state_q == SEQ_ACCESS) && !req_i.row_req && fast_mode
                     && req_i.col_hold && col_on;
    assign ext_d   = fast_mode && (ext_set || (ext_q && req_i.col_hold));

    always_comb begin
        state_d    = state_q;
        act_bank_d = act_bank_q;
        cnt_d      = cnt_q;
        unique case (state_q)
            SEQ_IDLE: begin
                if (start_access) begin
                    state_d    = SEQ_ACCESS;
                    act_bank_d = bank_i;
                    cnt_d      = '0;
                end else if (start_hidden_o) begin
                    state_d = SEQ_REFRESH;
                end
            end
            SEQ_ACCESS: begin
                if (!req_i.row_req) begin
                    state_d = SEQ_IDLE;
                end else if (cnt_q != CNT_LAST) begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            SEQ_REFRESH: begin
                if (!req_i.row_req) begin
                    state_d = SEQ_IDLE;
                end
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= SEQ_IDLE;
            act_bank_q <= '0;
            cnt_q      <= '0;
            ext_q      <= 1'b0;
            req_prev_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            act_bank_q <= act_bank_d;
            cnt_q      <= cnt_d;
            ext_q      <= ext_d;
            req_prev_q <= req_i.row_req;
        end
    end

    always_comb begin
        unique case (state_q)
            SEQ_ACCESS:  row_n_o = ~bank_enable(act_bank_q);
            SEQ_REFRESH: row_n_o = '0;
            default:     row_n_o = '1;
        endcase
    end

    assign col_n_o = !(col_on || ext_q);

    assert_single_row_R2: assert property (@(posedge clk) disable iff (rst)
        (row_n_o == '0) || ($countones(~row_n_o) <= 1));

    assert_refresh_all_R7: assert property (@(posedge clk) disable iff (rst)
        start_hidden_o |=> (row_n_o == '0));

    assert_access_end_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_ACCESS && !req_i.row_req) |=> (row_n_o == '1));

    assert_no_ext_normal_R6: assert property (@(posedge clk) disable iff (rst)
        ($past(!fast_mode) && !fast_mode && row_n_o == '1) |-> col_n_o);

endmodule

// File: rtl/dram_strobe_ctrl.sv
module dram_strobe_ctrl
    import dsc_pkg::*;
#(
    parameter int unsigned CAS_DELAY = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 fast_mode,
    input  logic                 addr_strobe,
    input  logic [BANK_W-1:0]    bank_code,
    input  logic                 sel_n,
    input  logic                 row_req_n,
    input  logic                 col_hold_n,
    input  logic                 refresh_clk,
    output logic [NUM_BANKS-1:0] row_strobe_n,
    output logic                 col_strobe_n,
    output logic                 refresh_req
);

    strobe_in_t        req_in;
    logic [BANK_W-1:0] bank_q;
    logic              hidden_ok;
    logic              start_hidden;

    assign req_in.row_req  = !row_req_n;
    assign req_in.sel      = !sel_n;
    assign req_in.col_hold = !col_hold_n;

    dsc_bank_latch #(.W(BANK_W)) bank_latch_i (
        .clk     (clk),
        .rst     (rst),
        .capture (addr_strobe),
        .code_i  (bank_code),
        .code_o  (bank_q)
    );

    dsc_refresh_tracker refresh_i (
        .clk            (clk),
        .rst            (rst),
        .fast_mode      (fast_mode),
        .refresh_clk    (refresh_clk),
        .start_hidden_i (start_hidden),
        .hidden_ok_o    (hidden_ok),
        .refresh_req_o  (refresh_req)
    );

    dsc_strobe_seq #(.CAS_DELAY(CAS_DELAY)) seq_i (
        .clk            (clk),
        .rst            (rst),
        .fast_mode      (fast_mode),
        .req_i          (req_in),
        .bank_i         (bank_q),
        .hidden_ok_i    (hidden_ok),
        .row_n_o        (row_strobe_n),
        .col_n_o        (col_strobe_n),
        .start_hidden_o (start_hidden)
    );

endmodule

// File: tb/dram_strobe_ctrl_tb_top.sv
module dram_strobe_ctrl_tb_top;

    localparam int D = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fast_mode = 1'b0;
    logic       addr_strobe = 1'b0;
    logic [1:0] bank_code = 2'd0;
    logic       sel_n = 1'b1;
    logic       row_req_n = 1'b1;
    logic       col_hold_n = 1'b1;
    logic       refresh_clk = 1'b0;
    logic [3:0] row_strobe_n;
    logic       col_strobe_n;
    logic       refresh_req;

    int checks = 0;
    int fails  = 0;
    bit run_cmp = 1'b0;
    string cur_tag = "R1";

    always #2.5 clk = ~clk;

    dram_strobe_ctrl #(.CAS_DELAY(D)) dut_i (
        .clk(clk), .rst(rst), .fast_mode(fast_mode), .addr_strobe(addr_strobe),
        .bank_code(bank_code), .sel_n(sel_n), .row_req_n(row_req_n),
        .col_hold_n(col_hold_n), .refresh_clk(refresh_clk),
        .row_strobe_n(row_strobe_n), .col_strobe_n(col_strobe_n),
        .refresh_req(refresh_req)
    );

    // behavioural reference: 0 idle, 1 access, 2 refresh
    int m_mode, m_bank, m_abank, m_cnt;
    bit m_ext, m_done, m_req, m_rfprev, m_reqprev_n;

    always @(posedge clk) begin
        bit rise, ok, fall, hid, extset;
        int nmode, ncnt, nabank;
        if (rst) begin
            m_mode = 0; m_bank = 0; m_abank = 0; m_cnt = 0;
            m_ext = 0; m_done = 0; m_req = 0; m_rfprev = 0; m_reqprev_n = 1;
        end else begin
            rise = !fast_mode && refresh_clk && !m_rfprev;
            ok   = !fast_mode && (!m_done || rise);
            fall = !row_req_n && m_reqprev_n;
            hid = 0; extset = 0;
            nmode = m_mode; ncnt = m_cnt; nabank = m_abank;
            if (m_mode == 0) begin
                if (fall && !sel_n) begin nmode = 1; nabank = m_bank; ncnt = 0; end
                else if (fall && sel_n && ok) begin nmode = 2; hid = 1; end
            end else if (m_mode == 1) begin
                if (row_req_n) begin
                    nmode = 0;
                    extset = fast_mode && !col_hold_n && (m_cnt == D);
                end else if (m_cnt < D) ncnt = m_cnt + 1;
            end else if (row_req_n) nmode = 0;
            m_ext  = fast_mode && (extset || (m_ext && !col_hold_n));
            m_done = hid ? 1'b1 : (rise ? 1'b0 : m_done);
            m_req  = (fast_mode || hid) ? 1'b0 : (rise ? 1'b1 : m_req);
            if (addr_strobe) m_bank = bank_code;
            m_mode = nmode; m_cnt = ncnt; m_abank = nabank;
            m_rfprev = refresh_clk; m_reqprev_n = row_req_n;
        end
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        int er;
        if (run_cmp) begin
            er = (m_mode == 1) ? (~(1 << m_abank) & 4'hF) : (m_mode == 2 ? 0 : 4'hF);
            chk(cur_tag, "model row", int'(row_strobe_n), er);
            chk(cur_tag, "model col", int'(col_strobe_n),
                ((m_mode == 1 && m_cnt == D) || m_ext) ? 0 : 1);
            chk(cur_tag, "model refresh_req", int'(refresh_req), int'(m_req));
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic latch_bank(input int b);
        bank_code = 2'(b); addr_strobe = 1'b1;
        tick(1);
        addr_strobe = 1'b0; bank_code = 2'(3 - b);
        tick(1);
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        run_cmp = 1'b1;
        cur_tag = "R1";
        chk("R1", "row after reset", int'(row_strobe_n), 4'hF);
        chk("R1", "col after reset", int'(col_strobe_n), 1);
        chk("R1", "refresh_req after reset", int'(refresh_req), 0);

        // normal accesses on every bank
        for (int b = 0; b < 4; b++) begin
            cur_tag = "R2";
            latch_bank(b);
            sel_n = 1'b0; row_req_n = 1'b0;
            tick(1);
            chk("R2", "selected row", int'(row_strobe_n), ~(1 << b) & 4'hF);
            cur_tag = "R3";
            chk("R3", "col before delay", int'(col_strobe_n), 1);
            tick(D - 1);
            chk("R3", "col one clock early", int'(col_strobe_n), 1);
            tick(1);
            chk("R3", "col at delay", int'(col_strobe_n), 0);
            tick(2);
            cur_tag = "R4";
            row_req_n = 1'b1; sel_n = 1'b1;
            tick(1);
            chk("R4", "row released", int'(row_strobe_n), 4'hF);
            chk("R4", "col released", int'(col_strobe_n), 1);
            tick(1);
        end

        // normal mode ignores column hold
        cur_tag = "R6";
        latch_bank(1);
        sel_n = 1'b0; row_req_n = 1'b0;
        tick(D + 2);
        col_hold_n = 1'b0; row_req_n = 1'b1; sel_n = 1'b1;
        tick(1);
        chk("R6", "normal mode no extension", int'(col_strobe_n), 1);
        col_hold_n = 1'b1;
        tick(2);

        // fast mode with extension
        fast_mode = 1'b1;
        cur_tag = "R5";
        latch_bank(2);
        sel_n = 1'b0; row_req_n = 1'b0;
        tick(1);
        chk("R3", "fast mode row", int'(row_strobe_n), 4'hB);
        tick(D);
        chk("R3", "fast mode col at delay", int'(col_strobe_n), 0);
        col_hold_n = 1'b0;
        tick(1);
        row_req_n = 1'b1; sel_n = 1'b1;
        tick(1);
        chk("R5", "row ends under hold", int'(row_strobe_n), 4'hF);
        chk("R5", "col extended", int'(col_strobe_n), 0);
        tick(3);
        chk("R5", "col still extended", int'(col_strobe_n), 0);
        col_hold_n = 1'b1;
        tick(1);
        chk("R5", "extension ended", int'(col_strobe_n), 1);
        tick(1);

        // fast mode without hold
        cur_tag = "R6";
        sel_n = 1'b0; row_req_n = 1'b0;
        tick(D + 2);
        row_req_n = 1'b1; sel_n = 1'b1;
        tick(1);
        chk("R6", "fast no hold no extension", int'(col_strobe_n), 1);
        tick(1);

        // fast mode: refresh clock and hidden refresh ignored
        cur_tag = "R11";
        refresh_clk = 1'b1; tick(2);
        chk("R11", "no refresh_req in fast mode", int'(refresh_req), 0);
        refresh_clk = 1'b0; tick(1);
        row_req_n = 1'b0;
        tick(1);
        chk("R11", "no hidden refresh in fast mode", int'(row_strobe_n), 4'hF);
        row_req_n = 1'b1; tick(2);
        fast_mode = 1'b0;
        tick(1);

        // hidden refresh in normal mode (none used since reset)
        cur_tag = "R10";
        refresh_clk = 1'b1;
        tick(1);
        chk("R10", "refresh_req set on edge", int'(refresh_req), 1);
        cur_tag = "R7";
        row_req_n = 1'b0;
        tick(1);
        chk("R7", "all rows low", int'(row_strobe_n), 0);
        chk("R7", "col high in refresh", int'(col_strobe_n), 1);
        chk("R10", "refresh_req cleared by hidden refresh", int'(refresh_req), 0);
        tick(2);
        chk("R7", "rows held low", int'(row_strobe_n), 0);
        row_req_n = 1'b1;
        tick(1);
        chk("R7", "rows released", int'(row_strobe_n), 4'hF);
        tick(1);

        cur_tag = "R8";
        row_req_n = 1'b0;
        tick(1);
        chk("R8", "second hidden refresh refused", int'(row_strobe_n), 4'hF);
        tick(1);
        row_req_n = 1'b1;
        tick(2);

        cur_tag = "R9";
        refresh_clk = 1'b0; tick(2);
        refresh_clk = 1'b1; tick(2);
        row_req_n = 1'b0;
        tick(1);
        chk("R9", "hidden refresh after new period", int'(row_strobe_n), 0);
        row_req_n = 1'b1;
        tick(3);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule